// File: doc/BRIEF.md
# Iterative Multiply/Divide Peripheral

This block is an arithmetic helper that sits on the register bus of a small 8-bit controller. Software loads a 32-bit operand/result register and a 16-bit operand register one byte at a time, then writes the control register to launch either an unsigned 16x16 multiplication or an unsigned 32/16 division. The block works through the operation one bit per clock and raises a one-cycle interrupt request when it is done. Software then reads the product, or the quotient and remainder, back byte by byte.

The control register starts and cancels work. Setting its run bit while idle launches an operation and clears the remainder register. A multiply launch also clears the upper half of the operand/result register. Clearing the run bit while an operation is in flight cancels it without an interrupt. If that cancel write lands on the same cycle as the final step, the operation still completes. A zero divisor gives a defined pattern and the normal run length, so the block never stalls.

Top module: `md_unit`

## Requirements
- R1: After reset every readable register returns 0, `busy` is 0 and `irq_req` is 0.
- R2: Register map by byte address: 0..3 are the operand/result register A (address 0 is the least significant byte), 4..5 are operand B (4 is the low byte), 6..7 are the remainder (6 is the low byte, read-only, and writes to it are ignored), and 8 is control. Written bytes of A and B read back unchanged while idle.
- R3: Writing control with bit 7 = 1 while idle starts an operation. Bit 0 of the same write selects the mode: 1 means multiply and 0 means divide. Control then reads bit 7 = 1, bit 0 = mode, and all other bits 0. The `busy` output is 1 from the cycle after the start write.
- R4: A start clears the remainder register to 0. A multiply start also clears A[31:16]. Both take effect in the cycle after the start write.
- R5: Multiply leaves A = A[15:0] * B, as a 32-bit unsigned product, exactly 16 cycles after the start write.
- R6: Divide leaves A = A / B and remainder = A mod B, both unsigned, exactly 32 cycles after the start write.
- R7: On completion `busy` and control bit 7 return to 0, and `irq_req` is 1 for exactly one cycle. That cycle is the one in which the result first becomes valid.
- R8: Writing control with bit 7 = 0 while busy, before the final step, stops the operation. `busy` is 0 in the next cycle and `irq_req` does not assert.
- R9: If a write with control bit 7 = 0 lands on the cycle of the final step, the operation completes: the result is kept and `irq_req` pulses.
- R10: A divide by a zero divisor still finishes in 32 cycles, with A = 0xFFFFFFFF and the remainder equal to the low 16 bits of the dividend.
- R11: Writing control with bit 7 = 1 while busy does not restart the run. Completion stays at the original cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Byte register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| busy | output | 1 | High while an operation is in progress |
| irq_req | output | 1 | One-cycle completion interrupt request |

## Verification
The run-length property assumes that the mode bit is not changed while a run is in flight. Rewriting the same mode is allowed, because the checker takes the expected length from the mode captured at start. The bench keeps to this rule: every control write made while busy either repeats the current mode or is a cancel. Operands are loaded only while idle, so every completed run can be compared with a product or quotient computed in the bench.

// File: rtl/md_pkg.sv
package md_pkg;

    // Operand width and byte width of the register port
    localparam int unsigned OPW     = 16;
    localparam int unsigned ACCW    = 2 * OPW;
    localparam int unsigned DW      = 8;

    // Byte-addressed map
    localparam int unsigned A_BYTES   = ACCW / DW;
    localparam int unsigned B_BYTES   = OPW / DW;
    localparam int unsigned A_BASE    = 0;
    localparam int unsigned B_BASE    = A_BASE + A_BYTES;
    localparam int unsigned R_BASE    = B_BASE + B_BYTES;
    localparam int unsigned CTRL_ADDR = R_BASE + B_BYTES;
    localparam int unsigned AW        = $clog2(CTRL_ADDR + 1);

    // Control bit positions
    localparam int unsigned CTRL_EN_BIT   = 7;
    localparam int unsigned CTRL_MODE_BIT = 0;

    // Step counts
    localparam int unsigned MUL_STEPS = OPW;
    localparam int unsigned DIV_STEPS = ACCW;
    localparam int unsigned CNTW      = $clog2(DIV_STEPS);

    typedef enum logic {
        MODE_DIV = 1'b0,
        MODE_MUL = 1'b1
    } md_mode_e;

    typedef struct packed {
        logic            we;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
    } md_bus_t;

    typedef struct packed {
        logic [ACCW-1:0] a;
        logic [OPW-1:0]  r;
    } md_state_t;

    typedef struct packed {
        logic     start;
        logic     start_mul;
        logic     step;
        md_mode_e mode;
    } md_ctl_t;

    // One shift-add multiply step: multiplier bits sit in a[OPW-1:0],
    // partial product accumulates in a[ACCW-1:OPW].
    function automatic md_state_t mul_step(input md_state_t s, input logic [OPW-1:0] b);
        md_state_t o;
        logic [OPW:0] sum;
        sum = {1'b0, s.a[ACCW-1:OPW]} + (s.a[0] ? {1'b0, b} : {(OPW+1){1'b0}});
        o.a = {sum, s.a[OPW-1:1]};
        o.r = s.r;
        return o;
    endfunction

    // One restoring divide step: partial remainder lives in r, dividend
    // shifts out of a's top while quotient bits shift in at the bottom.
    function automatic md_state_t div_step(input md_state_t s, input logic [OPW-1:0] b);
        md_state_t o;
        logic [OPW:0] t;
        t = {s.r, s.a[ACCW-1]};
        if (t >= {1'b0, b}) begin
            o.r = OPW'(t - {1'b0, b});
            o.a = {s.a[ACCW-2:0], 1'b1};
        end else begin
            o.r = t[OPW-1:0];
            o.a = {s.a[ACCW-2:0], 1'b0};
        end
        return o;
    endfunction

endpackage

// File: rtl/md_seq.sv
module md_seq
    import md_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ctrl_wr,
    input  logic    ctrl_en,
    input  logic    ctrl_mode,
    output md_ctl_t ctl,
    output logic    busy,
    output logic    irq_req
);

    localparam logic [CNTW-1:0] MUL_LAST = CNTW'(MUL_STEPS - 1);
    localparam logic [CNTW-1:0] DIV_LAST = CNTW'(DIV_STEPS - 1);

    logic            busy_q;
    logic            irq_q;
    logic [CNTW-1:0] cnt_q;
    md_mode_e        mode_q;

    logic            start;
    logic            last;
    logic            abort;
    logic [CNTW-1:0] limit;

    assign limit = (mode_q == MODE_MUL) ? MUL_LAST : DIV_LAST;
    assign start = ctrl_wr && ctrl_en && !busy_q;
    assign last  = busy_q && (cnt_q >= limit);
    // completion takes priority over a cancel landing on the last step
    assign abort = ctrl_wr && !ctrl_en && busy_q && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
            cnt_q  <= '0;
            mode_q <= MODE_DIV;
        end else begin
            irq_q <= last;
            if (ctrl_wr) begin
                mode_q <= md_mode_e'(ctrl_mode);
            end
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (last || abort) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ctl.start     = start;
    assign ctl.start_mul = ctrl_mode;
    assign ctl.step      = busy_q;
    assign ctl.mode      = mode_q;
    assign busy          = busy_q;
    assign irq_req       = irq_q;

endmodule

// File: rtl/md_arith.sv
module md_arith
    import md_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  md_bus_t         bus,
    input  md_ctl_t         ctl,
    output logic [ACCW-1:0] a_q,
    output logic [OPW-1:0]  b_q,
    output logic [OPW-1:0]  r_q
);

    logic [A_BYTES-1:0] a_we;
    logic [B_BYTES-1:0] b_we;

    for (genvar i = 0; i < A_BYTES; i++) begin : g_a_we
        assign a_we[i] = bus.we && (bus.addr == AW'(A_BASE + i));
    end
    for (genvar i = 0; i < B_BYTES; i++) begin : g_b_we
        assign b_we[i] = bus.we && (bus.addr == AW'(B_BASE + i));
    end

    md_state_t        cur;
    md_state_t        nxt;
    logic [OPW-1:0]   b_nxt;

    assign cur = '{a: a_q, r: r_q};

    always_comb begin
        nxt = cur;
        if (ctl.start) begin
            nxt.r = '0;
            if (ctl.start_mul) begin
                nxt.a[ACCW-1:OPW] = '0;
            end
        end else if (ctl.step) begin
            if (ctl.mode == MODE_MUL) begin
                nxt = mul_step(cur, b_q);
            end else begin
                nxt = div_step(cur, b_q);
            end
        end
        // bus writes land on top of any step in progress
        for (int i = 0; i < A_BYTES; i++) begin
            if (a_we[i]) begin
                nxt.a[i*DW +: DW] = bus.wdata;
            end
        end
    end

    always_comb begin
        b_nxt = b_q;
        for (int i = 0; i < B_BYTES; i++) begin
            if (b_we[i]) begin
                b_nxt[i*DW +: DW] = bus.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            r_q <= '0;
        end else begin
            a_q <= nxt.a;
            b_q <= b_nxt;
            r_q <= nxt.r;
        end
    end

endmodule

// File: rtl/md_rdmux.sv
module md_rdmux
    import md_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic [ACCW-1:0] a_q,
    input  logic [OPW-1:0]  b_q,
    input  logic [OPW-1:0]  r_q,
    input  logic            busy,
    input  md_mode_e        mode,
    output logic [DW-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < A_BYTES; i++) begin
            if (addr == AW'(A_BASE + i)) rdata = a_q[i*DW +: DW];
        end
        for (int i = 0; i < B_BYTES; i++) begin
            if (addr == AW'(B_BASE + i)) rdata = b_q[i*DW +: DW];
            if (addr == AW'(R_BASE + i)) rdata = r_q[i*DW +: DW];
        end
        if (addr == AW'(CTRL_ADDR)) begin
            rdata[CTRL_EN_BIT]   = busy;
            rdata[CTRL_MODE_BIT] = mode;
        end
    end

endmodule

// File: rtl/md_unit.sv
module md_unit
    import md_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          irq_req
);

    md_bus_t         bus;
    md_ctl_t         ctl;
    logic [ACCW-1:0] a_q;
    logic [OPW-1:0]  b_q;
    logic [OPW-1:0]  r_q;
    logic            ctrl_wr;
    logic            ctrl_en;
    logic            ctrl_mode;

    assign bus       = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign ctrl_wr   = bus_we && (bus_addr == AW'(CTRL_ADDR));
    assign ctrl_en   = bus_wdata[CTRL_EN_BIT];
    assign ctrl_mode = bus_wdata[CTRL_MODE_BIT];

    md_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_en   (ctrl_en),
        .ctrl_mode (ctrl_mode),
        .ctl       (ctl),
        .busy      (busy),
        .irq_req   (irq_req)
    );

    md_arith u_arith (
        .clk (clk),
        .rst (rst),
        .bus (bus),
        .ctl (ctl),
        .a_q (a_q),
        .b_q (b_q),
        .r_q (r_q)
    );

    md_rdmux u_rdmux (
        .addr  (bus_addr),
        .a_q   (a_q),
        .b_q   (b_q),
        .r_q   (r_q),
        .busy  (busy),
        .mode  (ctl.mode),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk
    import md_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           ctrl_wr,
    input logic           ctrl_en,
    input logic           ctrl_mode,
    input logic           busy,
    input logic           irq_req,
    input logic [OPW-1:0] a_hi,
    input logic [OPW-1:0] r_q
);

    localparam int unsigned LENW = CNTW + 2;

    logic            start_w;
    logic            cancel_w;
    logic [LENW-1:0] run_len;
    logic            run_mul;

    assign start_w  = ctrl_wr && ctrl_en && !busy;
    assign cancel_w = ctrl_wr && !ctrl_en && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            run_mul <= 1'b0;
        end else if (start_w) begin
            run_len <= '0;
            run_mul <= ctrl_mode;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_w |=> busy);

    // R4
    start_rem_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (r_q == '0));

    // R4
    mul_hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_w && ctrl_mode) |=> (a_hi == '0));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req);

    // R7
    irq_on_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (!busy && $past(busy)));

    // R8
    cancel_stops_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_w |=> !busy);

    // R8
    fall_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (irq_req || $past(cancel_w)));

    // R5 R6
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (run_len == (run_mul ? LENW'(MUL_STEPS) : LENW'(DIV_STEPS))));

endmodule

bind md_unit md_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_en   (ctrl_en),
    .ctrl_mode (ctrl_mode),
    .busy      (busy),
    .irq_req   (irq_req),
    .a_hi      (a_q[md_pkg::ACCW-1:md_pkg::OPW]),
    .r_q       (r_q)
);

// File: tb/md_unit_tb_top.sv
`timescale 1ns/1ps
module md_unit_tb_top;
    import md_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          busy;
    logic          irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    md_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .irq_req   (irq_req)
    );

    localparam logic [AW-1:0] CTRL = AW'(CTRL_ADDR);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input int addr, input logic [7:0] d);
        bus_we    = 1'b1;
        bus_addr  = AW'(addr);
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [7:0] d);
        bus_addr = AW'(addr);
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_a(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(A_BASE + i, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic rd_r(output logic [15:0] v);
        logic [7:0] b;
        for (int i = 0; i < 2; i++) begin
            rd(R_BASE + i, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic load(input logic [31:0] a, input logic [15:0] b);
        for (int i = 0; i < 4; i++) wr(A_BASE + i, a[i*8 +: 8]);
        for (int i = 0; i < 2; i++) wr(B_BASE + i, b[i*8 +: 8]);
    endtask

    // start, count the run, check completion cycle
    task automatic run_op(input bit mul, input string req);
        int n;
        logic [7:0] c;
        n = mul ? MUL_STEPS : DIV_STEPS;
        wr(CTRL_ADDR, mul ? 8'h81 : 8'h80);
        rd(CTRL_ADDR, c);
        check("R3 ctrl readback busy", {24'd0, c}, {24'd0, 8'h80 | {7'd0, mul}});
        check("R3 busy after start", {31'd0, busy}, 32'd1);
        repeat (n - 1) @(negedge clk);
        check({req, " busy one cycle before end"}, {31'd0, busy}, 32'd1);
        check("R7 no early irq", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        check({req, " busy cleared at end"}, {31'd0, busy}, 32'd0);
        check("R7 irq at end", {31'd0, irq_req}, 32'd1);
        rd(CTRL_ADDR, c);
        check("R7 ctrl enable bit cleared", {31'd0, c[7]}, 32'd0);
    endtask

    task automatic irq_drop;
        @(negedge clk);
        check("R7 irq single cycle", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int i = 0; i <= int'(CTRL_ADDR); i++) begin
            rd(i, d);
            check("R1 register reset value", {24'd0, d}, 32'd0);
        end
        check("R1 busy reset", {31'd0, busy}, 32'd0);
        check("R1 irq reset", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_regmap;
        logic [31:0] a;
        logic [7:0]  d;
        logic [15:0] r;
        load(32'h44332211, 16'h6655);
        rd_a(a);
        check("R2 A byte order", a, 32'h44332211);
        rd(B_BASE, d);     check("R2 B low byte", {24'd0, d}, 32'h55);
        rd(B_BASE + 1, d); check("R2 B high byte", {24'd0, d}, 32'h66);
        wr(R_BASE, 8'hFF);
        wr(R_BASE + 1, 8'hEE);
        rd_r(r);
        check("R2 remainder read-only", {16'd0, r}, 32'd0);
    endtask

    task automatic t_div(input logic [31:0] a, input logic [15:0] b);
        logic [31:0] q;
        logic [15:0] r;
        load(a, b);
        run_op(1'b0, "R6");
        rd_a(q);
        rd_r(r);
        check("R6 quotient", q, a / {16'd0, b});
        check("R6 remainder", {16'd0, r}, a % {16'd0, b});
        irq_drop();
    endtask

    task automatic t_mul(input logic [31:0] a, input logic [15:0] b, input bit chk_clear);
        logic [31:0] p;
        logic [15:0] r;
        logic [7:0]  d;
        int n;
        load(a, b);
        wr(CTRL_ADDR, 8'h81);
        if (chk_clear) begin
            rd_r(r);
            check("R4 remainder cleared at start", {16'd0, r}, 32'd0);
            rd(A_BASE + 2, d); check("R4 A high cleared (byte 2)", {24'd0, d}, 32'd0);
            rd(A_BASE + 3, d); check("R4 A high cleared (byte 3)", {24'd0, d}, 32'd0);
        end
        n = MUL_STEPS;
        repeat (n - 1) @(negedge clk);
        check("R5 busy before end", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R5 busy cleared", {31'd0, busy}, 32'd0);
        check("R7 irq at mul end", {31'd0, irq_req}, 32'd1);
        rd_a(p);
        check("R5 product", p, {16'd0, a[15:0]} * {16'd0, b});
        irq_drop();
    endtask

    task automatic t_div0;
        logic [31:0] q;
        logic [15:0] r;
        load(32'h12345678, 16'h0000);
        run_op(1'b0, "R10");
        rd_a(q);
        rd_r(r);
        check("R10 div0 quotient", q, 32'hFFFFFFFF);
        check("R10 div0 remainder", {16'd0, r}, 32'h5678);
        irq_drop();
    endtask

    task automatic t_abort;
        logic [7:0] c;
        bit seen;
        load(32'd1000, 16'd3);
        wr(CTRL_ADDR, 8'h80);
        repeat (3) @(negedge clk);
        wr(CTRL_ADDR, 8'h00);
        check("R8 busy cleared after cancel", {31'd0, busy}, 32'd0);
        rd(CTRL_ADDR, c);
        check("R8 ctrl reads idle", {24'd0, c}, 32'd0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (irq_req) seen = 1;
            @(negedge clk);
        end
        check("R8 no irq after cancel", {31'd0, seen}, 32'd0);
    endtask

    task automatic t_collide;
        logic [31:0] p;
        load(32'h00000003, 16'd5);
        wr(CTRL_ADDR, 8'h81);
        repeat (MUL_STEPS - 1) @(negedge clk);
        wr(CTRL_ADDR, 8'h01);
        check("R9 completion kept busy low", {31'd0, busy}, 32'd0);
        check("R9 irq on collision", {31'd0, irq_req}, 32'd1);
        rd_a(p);
        check("R9 result kept", p, 32'd15);
        irq_drop();
    endtask

    task automatic t_restart;
        logic [31:0] p;
        load(32'd100, 16'd200);
        wr(CTRL_ADDR, 8'h81);
        repeat (4) @(negedge clk);
        wr(CTRL_ADDR, 8'h81);
        repeat (MUL_STEPS - 6) @(negedge clk);
        check("R11 still busy at original end-1", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R11 irq at original end", {31'd0, irq_req}, 32'd1);
        rd_a(p);
        check("R11 product intact", p, 32'd20000);
        irq_drop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_div(32'hFFFFFFFF, 16'hFFFF);
        t_div(32'd1000000, 16'd7);
        t_mul(32'hDEAD0003, 16'd7, 1'b1);
        t_div(32'd5, 16'd9);
        t_mul(32'h0000FFFF, 16'hFFFF, 1'b0);
        t_mul(32'h00001234, 16'h5678, 1'b0);
        t_mul(32'h00000000, 16'hABCD, 1'b0);
        t_div0();
        t_abort();
        t_collide();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule